// File: doc/BRIEF.md
# Configurable Serial Receive Word Formatter

This block takes a serial sample stream, one bit per bit-clock cycle, and turns each sample into a 32-bit receive word. A start strobe marks the first bit of a sample. The block then counts off the configured number of bits and places the finished sample in the word. The configuration sets the sample length, the order in which the bits arrive, whether the word sits at the top or the bottom of the register, and whether the upper bits are filled with the sign.

Finished words go into a small buffer. The buffer can hold eight words, or it can be restricted to one. A ready flag tells the reader when to collect them, and each read strobe pops one word. If a word completes while the buffer is full, the word is dropped and a sticky overrun flag is raised. The configuration inputs are captured when a sample starts, so the controlling logic may change them at any time without corrupting a word already in progress.

Top module: `srx_word_rx`

## Requirements
- R1: `wl_code_i` selects the sample length: 0=8, 1=10, 2=12, 3=16, 4=18, 5=20, 6=22, 7=24 bits. The bit on `sd_i` in the cycle with `ws_i` high is the first bit. The word is stored at the clock edge that samples the last bit.
- R2: With `lsb_first_i`=0 the first bit received is the sample's most significant bit. With `lsb_first_i`=1 it is the least significant bit.
- R3: With `lsb_align_i`=0 the sample's MSB sits at bit 31 for lengths 16 to 24, and at bit 15 for lengths 8, 10 and 12. All other bits are zero.
- R4: With `lsb_align_i`=1 the sample occupies bits [len-1:0]. The bits above it are zero unless R5 applies.
- R5: With `sext_i`=1 and `lsb_align_i`=1, every bit above the sample copies the sample's MSB. With `lsb_align_i`=0, `sext_i` has no effect.
- R6: With `fifo_en_i`=1 the buffer holds eight words. `rdy_o` is high only while all eight are held, and it drops as soon as a read leaves fewer.
- R7: With `fifo_en_i`=0 the buffer holds one word, and `rdy_o` is high whenever that word is present.
- R8: A word that completes while the buffer is full is discarded and `ovr_o` is set. `ovr_o` stays high until `clr_ovr_i` is pulsed.
- R9: All configuration inputs are captured in the `ws_i` cycle. Changing them during a sample does not affect that sample.
- R10: `rst_ni` low clears the stored configuration to length 8, MSB first, MSB aligned, no extension and buffer disabled. It also empties the buffer and clears `rdy_o` and `ovr_o`.
- R11: `srst_i` empties the buffer, clears `ovr_o` and abandons any sample in progress, so bits that follow without a new `ws_i` store nothing.
- R12: `rdata_o` shows the oldest word. `rd_i` pops words in arrival order, and a read while the buffer is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| srst_i | input | 1 | Synchronous receiver soft reset |
| ws_i | input | 1 | Start strobe, high during the first bit of a sample |
| sd_i | input | 1 | Serial data |
| wl_code_i | input | 3 | Sample length code |
| lsb_first_i | input | 1 | First bit is the sample LSB |
| lsb_align_i | input | 1 | Place the sample at bit 0 |
| sext_i | input | 1 | Sign-fill upper bits when aligned at bit 0 |
| fifo_en_i | input | 1 | Use the eight-word buffer |
| rd_i | input | 1 | Pop one word |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| rdata_o | output | 32 | Oldest stored word |
| rdy_o | output | 1 | Data-ready flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Every combination of length, bit order, alignment and extension is run twice: once with a sample whose MSB is clear and once with one whose MSB is set. This separates sign filling from zero filling and shows whether a placement shift is off by one. Filling the buffer one word at a time, and then adding a ninth word, shows whether the ready threshold is wrong by one and whether an overflowing word is dropped or overwrites a stored one. Changing the configuration in the middle of a sample, and cutting off a sample with a soft reset, tests whether the configuration is captured at the start strobe and whether a partial sample is discarded.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int WORD_W = 32;
  localparam int RAW_W  = 24;

  typedef struct packed {
    logic [2:0] wl_code;
    logic       lsb_first;
    logic       lsb_align;
    logic       sext;
    logic       fifo_en;
  } srx_cfg_t;

  function automatic logic [4:0] wl_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd8;
      3'd1:    return 5'd10;
      3'd2:    return 5'd12;
      3'd3:    return 5'd16;
      3'd4:    return 5'd18;
      3'd5:    return 5'd20;
      3'd6:    return 5'd22;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  srx_cfg_t         cfg_i,
  output srx_cfg_t         cfg_o,
  output logic             done_o,
  output logic [RAW_W-1:0] raw_o
);
  logic             busy_q;
  logic [4:0]       bcnt_q;
  logic [RAW_W-1:0] sh_q, sh_base, sh_nxt;
  srx_cfg_t         cfg_q, cfg_use;

  always_comb begin
    cfg_use = ws_i ? cfg_i : cfg_q;
    sh_base = ws_i ? '0 : sh_q;
    sh_nxt  = cfg_use.lsb_first ? {sd_i, sh_base[RAW_W-1:1]} : {sh_base[RAW_W-2:0], sd_i};
    done_o  = busy_q && !ws_i && !srst_i && (bcnt_q == wl_bits(cfg_q.wl_code) - 5'd1);
  end

  assign raw_o = sh_nxt;
  assign cfg_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      sh_q   <= '0;
      cfg_q  <= '0;
    end else if (srst_i) begin
      // configuration survives a soft reset
      busy_q <= 1'b0;
      bcnt_q <= '0;
    end else if (ws_i) begin
      cfg_q  <= cfg_i;
      busy_q <= 1'b1;
      bcnt_q <= 5'd1;
      sh_q   <= sh_nxt;
    end else if (busy_q) begin
      sh_q   <= sh_nxt;
      bcnt_q <= bcnt_q + 5'd1;
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/srx_format.sv
module srx_format
  import srx_pkg::*;
(
  input  srx_cfg_t          cfg_i,
  input  logic [RAW_W-1:0]  raw_i,
  output logic [WORD_W-1:0] word_o
);
  logic [4:0]        wl;
  logic [5:0]        top_sh;
  logic [RAW_W-1:0]  raw_al;
  logic [WORD_W-1:0] val, mask;
  logic              msb;

  always_comb begin
    wl     = wl_bits(cfg_i.wl_code);
    raw_al = cfg_i.lsb_first ? (raw_i >> (5'd24 - wl)) : raw_i;
    val    = {{(WORD_W-RAW_W){1'b0}}, raw_al};
    mask   = (32'd1 << wl) - 32'd1;
    msb    = |((val >> (wl - 5'd1)) & 32'd1);
    top_sh = (wl >= 5'd16) ? (6'd32 - {1'b0, wl}) : (6'd16 - {1'b0, wl});
    if (cfg_i.lsb_align)
      word_o = (cfg_i.sext && msb) ? (val | ~mask) : val;
    else
      word_o = val << top_sh;
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          cap_one_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cap;
  logic          pop_ok, push_ok;

  always_comb begin
    cap     = cap_one_i ? CW'(1) : CW'(DEPTH);
    pop_ok  = pop_i && (cnt_q != '0);
    push_ok = push_i && ((cnt_q < cap) || pop_ok);
    drop_o  = push_i && !push_ok;
  end

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (srst_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= inc(wptr_q);
      if (pop_ok)  rptr_q <= inc(rptr_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !srst_i) mem_q[wptr_q] <= data_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/srx_word_rx.sv
module srx_word_rx
  import srx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic [2:0]  wl_code_i,
  input  logic        lsb_first_i,
  input  logic        lsb_align_i,
  input  logic        sext_i,
  input  logic        fifo_en_i,
  input  logic        rd_i,
  input  logic        clr_ovr_i,
  output logic [31:0] rdata_o,
  output logic        rdy_o,
  output logic        ovr_o
);
  srx_cfg_t          cfg_in, cfg_q;
  logic              done;
  logic [RAW_W-1:0]  raw;
  logic [WORD_W-1:0] word;
  logic [CW-1:0]     fifo_cnt;
  logic              drop, ovr_q;

  assign cfg_in = '{wl_code: wl_code_i, lsb_first: lsb_first_i, lsb_align: lsb_align_i,
                    sext: sext_i, fifo_en: fifo_en_i};

  srx_shift i_shift (
    .clk_i, .rst_ni, .srst_i, .ws_i, .sd_i,
    .cfg_i (cfg_in),
    .cfg_o (cfg_q),
    .done_o(done),
    .raw_o (raw)
  );

  srx_format i_format (
    .cfg_i (cfg_q),
    .raw_i (raw),
    .word_o(word)
  );

  srx_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .srst_i,
    .cap_one_i(!cfg_q.fifo_en),
    .push_i   (done),
    .data_i   (word),
    .pop_i    (rd_i),
    .rdata_o  (rdata_o),
    .cnt_o    (fifo_cnt),
    .drop_o   (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (srst_i)    ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (clr_ovr_i) ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;
  assign rdy_o = cfg_q.fifo_en ? (fifo_cnt == CW'(DEPTH)) : (fifo_cnt != '0);
endmodule

// File: rtl/srx_word_rx_chk.sv
module srx_word_rx_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srst_i,
  input logic          clr_ovr_i,
  input logic          ovr_o,
  input logic          rdy_o,
  input logic          fifo_en,
  input logic [CW-1:0] cnt
);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !clr_ovr_i && !srst_i |=> ovr_o);

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  // R6
  rdy_low_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en && (cnt < CW'(DEPTH)) |-> !rdy_o);

  // R7
  single_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |-> cnt <= CW'(1));

  // R12
  rdy_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> cnt != '0);

  // R11
  srst_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cnt == '0) && !ovr_o);
endmodule

bind srx_word_rx srx_word_rx_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .srst_i   (srst_i),
  .clr_ovr_i(clr_ovr_i),
  .ovr_o    (ovr_o),
  .rdy_o    (rdy_o),
  .fifo_en  (cfg_q.fifo_en),
  .cnt      (fifo_cnt)
);

// File: tb/test_srx_word_rx.sv
module test_srx_word_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [2:0]  wl_code = 3'd0;
  logic        lsb_first = 1'b0, lsb_align = 1'b0, sext = 1'b0, fifo_en = 1'b0;
  logic        rd = 1'b0, clr_ovr = 1'b0;
  logic [31:0] rdata;
  logic        rdy, ovr;
  int          n_tot = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  srx_word_rx i_srx_word_rx (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .ws_i(ws), .sd_i(sd),
    .wl_code_i(wl_code), .lsb_first_i(lsb_first), .lsb_align_i(lsb_align),
    .sext_i(sext), .fifo_en_i(fifo_en), .rd_i(rd), .clr_ovr_i(clr_ovr),
    .rdata_o(rdata), .rdy_o(rdy), .ovr_o(ovr)
  );

  function automatic int wl_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 10; 3'd2: return 12; 3'd3: return 16;
      3'd4: return 18; 3'd5: return 20; 3'd6: return 22; default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] expect_word(input int wl, input bit la, input bit sx,
                                              input logic [31:0] v);
    logic [31:0] m;
    m = (32'd1 << wl) - 32'd1;
    if (la) return (sx && v[wl-1]) ? ((v & m) | ~m) : (v & m);
    return (v & m) << ((wl >= 16) ? (32 - wl) : (16 - wl));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sends value v with the configuration currently on the inputs
  task automatic send(input logic [31:0] v);
    int wl;
    bit lf;
    wl = wl_of(wl_code);
    lf = lsb_first;
    for (int i = 0; i < wl; i++) begin
      @(negedge clk);
      ws = (i == 0);
      sd = lf ? v[i] : v[wl-1-i];
    end
    @(negedge clk);
    ws = 1'b0;
    sd = 1'b0;
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int k);
    return (32'h5A3C_96E1 * (k + 1)) ^ (32'h0F0F_1234 >> (k % 7));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    logic [31:0] vs [9];
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rdy", {31'd0, rdy}, 32'd0);
    check("R10 ovr", {31'd0, ovr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rdy after release", {31'd0, rdy}, 32'd0);

    // R1..R5, R7 sweep, buffer disabled
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        wl_code   = 3'(c);
        lsb_first = f[0];
        lsb_align = f[1];
        sext      = f[2];
        fifo_en   = 1'b0;
        v = pat(c * 16 + f);
        v[wl_of(3'(c)) - 1] = f[3];
        e = expect_word(wl_of(3'(c)), f[1], f[2], v);
        send(v);
        check("R7 rdy after one sample", {31'd0, rdy}, 32'd1);
        check($sformatf("R1 R2 R3 R4 R5 len=%0d lf=%0d la=%0d sx=%0d", wl_of(3'(c)),
                        f[0], f[1], f[2]), rdata, e);
        read_pulse();
        check("R12 rdy low after pop", {31'd0, rdy}, 32'd0);
      end

    // R9 config captured at start strobe
    wl_code = 3'd7; lsb_first = 1'b0; lsb_align = 1'b0; sext = 1'b0;
    v = 32'h00A5_C3E7;
    fork
      send(v);
      begin
        repeat (4) @(negedge clk);
        wl_code = 3'd0; lsb_align = 1'b1; sext = 1'b1; lsb_first = 1'b1; fifo_en = 1'b1;
      end
    join
    check("R9 mid-sample change ignored", rdata, expect_word(24, 1'b0, 1'b0, v));
    check("R9 rdy", {31'd0, rdy}, 32'd1);
    read_pulse();

    // R6 buffer threshold, R12 ordering
    wl_code = 3'd0; lsb_first = 1'b0; lsb_align = 1'b1; sext = 1'b0; fifo_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      vs[k] = pat(200 + k) & 32'hFF;
      send(vs[k]);
      check($sformatf("R6 rdy after %0d samples", k + 1), {31'd0, rdy}, (k == 7) ? 32'd1 : 32'd0);
    end
    check("R6 rdata oldest", rdata, vs[0]);
    read_pulse();
    check("R6 rdy drops below eight", {31'd0, rdy}, 32'd0);
    for (int k = 1; k < 8; k++) begin
      check($sformatf("R12 order %0d", k), rdata, vs[k]);
      read_pulse();
    end
    // R12 read while empty ignored
    read_pulse();
    read_pulse();
    check("R12 empty read rdy", {31'd0, rdy}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      vs[k] = pat(300 + k) & 32'hFF;
      send(vs[k]);
    end
    check("R12 after empty read rdy", {31'd0, rdy}, 32'd1);
    check("R12 after empty read data", rdata, vs[0]);
    for (int k = 0; k < 8; k++) read_pulse();

    // R8 overrun with buffer enabled
    for (int k = 0; k < 9; k++) begin
      vs[k] = pat(400 + k) & 32'hFF;
      send(vs[k]);
      check($sformatf("R8 ovr after %0d", k + 1), {31'd0, ovr}, (k == 8) ? 32'd1 : 32'd0);
    end
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R8 kept %0d", k), rdata, vs[k]);
      read_pulse();
    end
    check("R8 ovr sticky", {31'd0, ovr}, 32'd1);
    clr_ovr = 1'b1;
    @(negedge clk);
    clr_ovr = 1'b0;
    check("R8 ovr cleared", {31'd0, ovr}, 32'd0);

    // R8 R7 overrun with single-word buffer
    fifo_en = 1'b0;
    send(32'h11);
    send(32'h22);
    check("R7 R8 ovr single", {31'd0, ovr}, 32'd1);
    check("R7 R8 first kept", rdata, 32'h11);

    // R11 soft reset flushes and clears overrun
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    check("R11 rdy flushed", {31'd0, rdy}, 32'd0);
    check("R11 ovr cleared", {31'd0, ovr}, 32'd0);
    // R11 partial sample abandoned
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ws = (i == 0);
      sd = 1'b1;
      srst = (i == 3);
    end
    @(negedge clk);
    ws = 1'b0; sd = 1'b0; srst = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 partial dropped", {31'd0, rdy}, 32'd0);
    send(32'h3C);
    check("R11 recovers", rdata, 32'h3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule